// File: doc/BRIEF.md
# Priority Interrupt Source Router

This block picks, for each of twelve processor interrupt lines, one event out of a 128-wide event vector and forwards that event's level to the line. Line index n feeds processor priority level n+4, so line 0 is priority 4 and line 11 is priority 15. Events 0 to 3 are the combined group events produced by an upstream combiner. Events 4 and up are individual sources. Any of them may be chosen.

Each line has an 8-bit source field. The fields sit four to a 32-bit register and can be read and written over a simple register port with byte enables. Register word 0 is a reserved slot that holds nothing. The selector words follow it. A field value of 128 or more parks the line at 0. Every line output is registered, so a change on the selected event shows up on the line one clock later. Latching, masking and priority arbitration of the events belong to other blocks.

Top module: `prio_event_router`

## Requirements
- R1: While `rst` is high, and on the first clock after it, every `irq_out` bit is 0. After reset, field n holds the value n+4, so word 1 reads 0x07060504, word 2 reads 0x0B0A0908 and word 3 reads 0x0F0E0D0C.
- R2: When field n holds a value s below 128, `irq_out[n]` after a clock edge equals `evt_in[s]` as it was sampled at that edge.
- R3: The field for line n lives in register word 1 + n/4, at bits (n mod 4)*8 +: 8. Word 1 covers lines 0 to 3, word 2 covers lines 4 to 7 and word 3 covers lines 8 to 11.
- R4: A write to a selector word changes only the bytes whose `reg_be` bit is 1. Bit b of `reg_be` covers data bits 8b+7:8b.
- R5: A field value from 128 to 255 holds its line at 0 whatever the event vector is. The value 127 still selects event 127.
- R6: Word 0 always reads 0, and writes to it change no field and no output.
- R7: Words 4 to 7 always read 0, and writes to them change no field and no output.
- R8: A write accepted at a clock edge takes effect on the line at the next edge. The edge that accepts the write still uses the old source.
- R9: `reg_rdata` shows the addressed word one clock after `reg_re` is sampled high, and it holds its value while `reg_re` is low.
- R10: Several lines may select the same event, and each of them follows that event.
- R11: Combined group events 0 to 3 can be selected like any other event.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| evt_in | input | 128 | Event levels; bits 0 to 3 are combined group events |
| reg_we | input | 1 | Register write strobe |
| reg_re | input | 1 | Register read strobe |
| reg_addr | input | 3 | Word address |
| reg_wdata | input | 32 | Write data |
| reg_be | input | 4 | Byte enables for writes |
| reg_rdata | output | 32 | Registered read data |
| irq_out | output | 12 | Interrupt lines; bit n drives priority n+4 |

## Verification
The bench targets the byte placement of each field. A design that swaps lanes or words would route the wrong event, and the read-back would show the misplaced byte. It also exercises partial byte-enable writes, the reserved word 0 and the words above the map. Writes there that leaked into a field would change later outputs. Source values 127, 128 and 255 are driven against an all-ones event vector to show whether the range cut is off by one. Every write is scoreboarded in the cycle it is accepted, so a design that applied the new source one edge early or late would mismatch on that cycle.

// File: rtl/prio_event_router_pkg.sv
package prio_event_router_pkg;
  parameter int unsigned DEF_NUM_EVENTS = 128;
  parameter int unsigned DEF_NUM_OUTS   = 12;
  parameter int unsigned DEF_SEL_W      = 8;
  parameter int unsigned DEF_DATA_W     = 32;
  parameter int unsigned DEF_ADDR_W     = 3;
  parameter int unsigned DEF_FIRST_WORD = 1;
  parameter int unsigned DEF_RESET_BASE = 4;

  function automatic int unsigned ceil_div(input int unsigned a, input int unsigned b);
    return (a + b - 1) / b;
  endfunction
endpackage

// File: rtl/prio_sel_regs.sv
module prio_sel_regs
  import prio_event_router_pkg::*;
#(
  parameter int unsigned NUM_OUTS   = DEF_NUM_OUTS,
  parameter int unsigned SEL_W      = DEF_SEL_W,
  parameter int unsigned DATA_W     = DEF_DATA_W,
  parameter int unsigned ADDR_W     = DEF_ADDR_W,
  parameter int unsigned FIRST_WORD = DEF_FIRST_WORD,
  parameter int unsigned RESET_BASE = DEF_RESET_BASE
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         reg_we,
  input  logic [ADDR_W-1:0]            reg_addr,
  input  logic [DATA_W-1:0]            reg_wdata,
  input  logic [DATA_W/8-1:0]          reg_be,
  output logic [NUM_OUTS*SEL_W-1:0]    sel_flat
);
  localparam int unsigned FPW = DATA_W / SEL_W;
  localparam int unsigned BPF = SEL_W / 8;

  for (genvar n = 0; n < NUM_OUTS; n++) begin : g_field
    localparam int unsigned WORD = FIRST_WORD + n / FPW;
    localparam int unsigned LANE = n % FPW;
    logic [SEL_W-1:0] field_q;
    logic             hit;

    assign hit = reg_we && (int'(reg_addr) == int'(WORD));

    always_ff @(posedge clk) begin
      if (rst) begin
        field_q <= SEL_W'(n + RESET_BASE);
      end else if (hit) begin
        for (int b = 0; b < int'(BPF); b++) begin
          if (reg_be[LANE*BPF + b])
            field_q[b*8 +: 8] <= reg_wdata[LANE*SEL_W + b*8 +: 8];
        end
      end
    end

    assign sel_flat[n*SEL_W +: SEL_W] = field_q;
  end
endmodule

// File: rtl/prio_sel_lane.sv
module prio_sel_lane
  import prio_event_router_pkg::*;
#(
  parameter int unsigned NUM_EVENTS = DEF_NUM_EVENTS,
  parameter int unsigned SEL_W      = DEF_SEL_W
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [NUM_EVENTS-1:0] evt_in,
  input  logic [SEL_W-1:0]      sel,
  output logic                  irq_q
);
  localparam int unsigned IDX_W = $clog2(NUM_EVENTS);

  logic in_range;
  logic picked;

  assign in_range = ({1'b0, sel} < (SEL_W+1)'(NUM_EVENTS));
  assign picked   = in_range ? evt_in[sel[IDX_W-1:0]] : 1'b0;

  always_ff @(posedge clk) begin
    if (rst) irq_q <= 1'b0;
    else     irq_q <= picked;
  end
endmodule

// File: rtl/prio_sel_rdport.sv
module prio_sel_rdport
  import prio_event_router_pkg::*;
#(
  parameter int unsigned NUM_OUTS   = DEF_NUM_OUTS,
  parameter int unsigned SEL_W      = DEF_SEL_W,
  parameter int unsigned DATA_W     = DEF_DATA_W,
  parameter int unsigned ADDR_W     = DEF_ADDR_W,
  parameter int unsigned FIRST_WORD = DEF_FIRST_WORD
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      reg_re,
  input  logic [ADDR_W-1:0]         reg_addr,
  input  logic [NUM_OUTS*SEL_W-1:0] sel_flat,
  output logic [DATA_W-1:0]         reg_rdata
);
  localparam int unsigned FPW       = DATA_W / SEL_W;
  localparam int unsigned NUM_WORDS = ceil_div(NUM_OUTS, FPW);

  logic [NUM_WORDS-1:0][DATA_W-1:0] word_img;
  logic [DATA_W-1:0]                rd_word;

  for (genvar w = 0; w < NUM_WORDS; w++) begin : g_word
    for (genvar l = 0; l < FPW; l++) begin : g_lane
      if (w*FPW + l < NUM_OUTS) begin : g_used
        assign word_img[w][l*SEL_W +: SEL_W] = sel_flat[(w*FPW + l)*SEL_W +: SEL_W];
      end else begin : g_empty
        assign word_img[w][l*SEL_W +: SEL_W] = '0;
      end
    end
  end

  always_comb begin
    rd_word = '0;
    for (int w = 0; w < int'(NUM_WORDS); w++) begin
      if (int'(reg_addr) == int'(FIRST_WORD) + w) rd_word = word_img[w];
    end
  end

  always_ff @(posedge clk) begin
    if (rst)         reg_rdata <= '0;
    else if (reg_re) reg_rdata <= rd_word;
  end
endmodule

// File: rtl/prio_event_router.sv
module prio_event_router
  import prio_event_router_pkg::*;
#(
  parameter int unsigned NUM_EVENTS = DEF_NUM_EVENTS,
  parameter int unsigned NUM_OUTS   = DEF_NUM_OUTS,
  parameter int unsigned SEL_W      = DEF_SEL_W,
  parameter int unsigned DATA_W     = DEF_DATA_W,
  parameter int unsigned ADDR_W     = DEF_ADDR_W,
  parameter int unsigned FIRST_WORD = DEF_FIRST_WORD,
  parameter int unsigned RESET_BASE = DEF_RESET_BASE
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [NUM_EVENTS-1:0] evt_in,
  input  logic                  reg_we,
  input  logic                  reg_re,
  input  logic [ADDR_W-1:0]     reg_addr,
  input  logic [DATA_W-1:0]     reg_wdata,
  input  logic [DATA_W/8-1:0]   reg_be,
  output logic [DATA_W-1:0]     reg_rdata,
  output logic [NUM_OUTS-1:0]   irq_out
);
  logic [NUM_OUTS*SEL_W-1:0] sel_flat;

  prio_sel_regs #(
    .NUM_OUTS(NUM_OUTS), .SEL_W(SEL_W), .DATA_W(DATA_W),
    .ADDR_W(ADDR_W), .FIRST_WORD(FIRST_WORD), .RESET_BASE(RESET_BASE)
  ) u_regs (
    .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_be(reg_be), .sel_flat(sel_flat)
  );

  for (genvar n = 0; n < NUM_OUTS; n++) begin : g_out
    prio_sel_lane #(
      .NUM_EVENTS(NUM_EVENTS), .SEL_W(SEL_W)
    ) u_lane (
      .clk(clk), .rst(rst), .evt_in(evt_in),
      .sel(sel_flat[n*SEL_W +: SEL_W]), .irq_q(irq_out[n])
    );
  end

  prio_sel_rdport #(
    .NUM_OUTS(NUM_OUTS), .SEL_W(SEL_W), .DATA_W(DATA_W),
    .ADDR_W(ADDR_W), .FIRST_WORD(FIRST_WORD)
  ) u_rd (
    .clk(clk), .rst(rst), .reg_re(reg_re), .reg_addr(reg_addr),
    .sel_flat(sel_flat), .reg_rdata(reg_rdata)
  );
endmodule

// File: rtl/prio_event_router_chk.sv
module prio_event_router_chk
  import prio_event_router_pkg::*;
#(
  parameter int unsigned NUM_EVENTS = DEF_NUM_EVENTS,
  parameter int unsigned NUM_OUTS   = DEF_NUM_OUTS,
  parameter int unsigned SEL_W      = DEF_SEL_W,
  parameter int unsigned DATA_W     = DEF_DATA_W,
  parameter int unsigned ADDR_W     = DEF_ADDR_W,
  parameter int unsigned FIRST_WORD = DEF_FIRST_WORD
) (
  input logic                      clk,
  input logic                      rst,
  input logic [NUM_EVENTS-1:0]     evt_in,
  input logic                      reg_we,
  input logic                      reg_re,
  input logic [ADDR_W-1:0]         reg_addr,
  input logic [DATA_W/8-1:0]       reg_be,
  input logic [DATA_W-1:0]         reg_rdata,
  input logic [NUM_OUTS-1:0]       irq_out,
  input logic [NUM_OUTS*SEL_W-1:0] sel_flat
);
  localparam int unsigned IDX_W     = $clog2(NUM_EVENTS);
  localparam int unsigned FPW       = DATA_W / SEL_W;
  localparam int unsigned NUM_WORDS = ceil_div(NUM_OUTS, FPW);
  localparam int unsigned BPF       = SEL_W / 8;

  // R1
  reset_idle_chk: assert property (@(posedge clk) rst |=> (irq_out == '0));

  // R6
  reserved_word_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (reg_re && int'(reg_addr) < int'(FIRST_WORD)) |=> (reg_rdata == '0));

  // R7
  upper_word_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (reg_re && int'(reg_addr) >= int'(FIRST_WORD + NUM_WORDS)) |=> (reg_rdata == '0));

  // R9
  rdata_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !reg_re |=> $stable(reg_rdata));

  for (genvar n = 0; n < NUM_OUTS; n++) begin : g_line
    // R2
    route_follow_chk: assert property (@(posedge clk) disable iff (rst)
      ({1'b0, sel_flat[n*SEL_W +: SEL_W]} < (SEL_W+1)'(NUM_EVENTS))
      |=> (irq_out[n] == $past(evt_in[sel_flat[n*SEL_W +: IDX_W]])));

    // R5
    out_of_range_idle_chk: assert property (@(posedge clk) disable iff (rst)
      ({1'b0, sel_flat[n*SEL_W +: SEL_W]} >= (SEL_W+1)'(NUM_EVENTS))
      |=> !irq_out[n]);

    // R4
    masked_byte_keep_chk: assert property (@(posedge clk) disable iff (rst)
      (reg_we && int'(reg_addr) == int'(FIRST_WORD + n / FPW)
       && reg_be[(n % FPW)*BPF +: BPF] == '0)
      |=> $stable(sel_flat[n*SEL_W +: SEL_W]));
  end
endmodule

bind prio_event_router prio_event_router_chk #(
  .NUM_EVENTS(NUM_EVENTS), .NUM_OUTS(NUM_OUTS), .SEL_W(SEL_W),
  .DATA_W(DATA_W), .ADDR_W(ADDR_W), .FIRST_WORD(FIRST_WORD)
) u_chk (
  .clk(clk), .rst(rst), .evt_in(evt_in), .reg_we(reg_we), .reg_re(reg_re),
  .reg_addr(reg_addr), .reg_be(reg_be), .reg_rdata(reg_rdata),
  .irq_out(irq_out), .sel_flat(sel_flat)
);

// File: tb/prio_event_router_tb.sv
module prio_event_router_tb;
  localparam int NE = 128;
  localparam int NO = 12;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [NE-1:0] evt_in = '0;
  logic          reg_we = 1'b0;
  logic          reg_re = 1'b0;
  logic [2:0]    reg_addr = '0;
  logic [31:0]   reg_wdata = '0;
  logic [3:0]    reg_be = '0;
  logic [31:0]   reg_rdata;
  logic [NO-1:0] irq_out;

  int n_checks = 0;
  int n_fail = 0;
  bit done = 1'b0;

  typedef struct {
    logic [NO-1:0] exp;
    string         tag;
  } sb_item_t;

  sb_item_t      sb_q[$];
  logic [7:0]    model_sel[NO];
  string         cur_tag = "R1";
  logic [NE-1:0] evt_cur = '0;

  always #4 clk = ~clk;

  prio_event_router u_dut (
    .clk(clk), .rst(rst), .evt_in(evt_in), .reg_we(reg_we), .reg_re(reg_re),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_be(reg_be),
    .reg_rdata(reg_rdata), .irq_out(irq_out)
  );

  function automatic logic [NO-1:0] expect_irq(input logic [NE-1:0] ev);
    logic [NO-1:0] r;
    for (int n = 0; n < NO; n++) r[n] = (model_sel[n] < 8'd128) ? ev[model_sel[n][6:0]] : 1'b0;
    return r;
  endfunction

  function automatic logic [NE-1:0] pattern(input int k);
    logic [NE-1:0] p;
    for (int i = 0; i < 4; i++) p[i*32 +: 32] = (32'(k) + 1) * 32'h9E3779B9 ^ (32'(i) * 32'h85EBCA6B);
    return p;
  endfunction

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Monitor: runs at the falling edge, before the driver acts at +1.
  always @(negedge clk) begin
    if (!rst && sb_q.size() > 0) begin
      sb_item_t it;
      it = sb_q.pop_front();
      check(irq_out == it.exp, it.tag, 32'(irq_out), 32'(it.exp));
    end
  end

  task automatic model_write(input int addr, input logic [31:0] wd, input logic [3:0] be);
    if (addr >= 1 && addr <= 3)
      for (int l = 0; l < 4; l++)
        if (be[l]) model_sel[(addr-1)*4 + l] = wd[l*8 +: 8];
  endtask

  task automatic cycle(input bit we, input bit re, input int addr,
                       input logic [31:0] wd, input logic [3:0] be,
                       output logic [31:0] rd_seen);
    sb_item_t it;
    @(negedge clk); #1;
    rd_seen   = reg_rdata;
    evt_in    = evt_cur;
    reg_we    = we;
    reg_re    = re;
    reg_addr  = 3'(addr);
    reg_wdata = wd;
    reg_be    = be;
    it.exp = expect_irq(evt_cur);
    it.tag = cur_tag;
    sb_q.push_back(it);
    if (we) model_write(addr, wd, be);
  endtask

  task automatic idle();
    logic [31:0] d;
    cycle(0, 0, 0, '0, '0, d);
  endtask

  task automatic wr(input int addr, input logic [31:0] wd, input logic [3:0] be);
    logic [31:0] d;
    cycle(1, 0, addr, wd, be, d);
  endtask

  task automatic rd(input int addr, input logic [31:0] exp, input string tag);
    logic [31:0] d;
    cycle(0, 1, addr, '0, '0, d);
    cycle(0, 0, 0, '0, '0, d);
    check(d == exp, tag, d, exp);
  endtask

  task automatic rd_model(input int addr, input string tag);
    logic [31:0] e;
    e = '0;
    if (addr >= 1 && addr <= 3)
      for (int l = 0; l < 4; l++) e[l*8 +: 8] = model_sel[(addr-1)*4 + l];
    rd(addr, e, tag);
  endtask

  initial begin
    logic [31:0] d;
    for (int n = 0; n < NO; n++) model_sel[n] = 8'(n + 4);
    evt_in = '1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: outputs idle during reset even with all events high
    check(irq_out == '0, "R1", 32'(irq_out), 32'h0);
    #1 rst = 1'b0;

    cur_tag = "R1";
    evt_cur = '1;
    idle();
    rd(1, 32'h07060504, "R1");
    rd(2, 32'h0B0A0908, "R1");
    rd(3, 32'h0F0E0D0C, "R1");

    // R2: default routing under varied event patterns
    cur_tag = "R2";
    for (int k = 0; k < 12; k++) begin evt_cur = pattern(k); idle(); end
    for (int k = 0; k < NO; k++) begin evt_cur = '0; evt_cur[k+4] = 1'b1; idle(); end

    // R11 / R3 / R8: combined events on lines 0..3, new source from next edge
    cur_tag = "R8";
    evt_cur = pattern(20);
    wr(1, 32'h00010203, 4'hF);
    idle();
    cur_tag = "R11";
    for (int k = 0; k < 16; k++) begin evt_cur = '0; evt_cur[3:0] = 4'(k); idle(); end
    rd_model(1, "R3");

    // R3: distinct sources per line across words 2 and 3
    cur_tag = "R3";
    wr(2, 32'h28201810, 4'hF);
    wr(3, 32'h7F605040, 4'hF);
    for (int k = 30; k < 40; k++) begin evt_cur = pattern(k); idle(); end
    rd_model(2, "R3");
    rd_model(3, "R3");

    // R4: partial byte enables
    cur_tag = "R4";
    wr(2, 32'h11223344, 4'b0101);
    rd(2, 32'h28221844, "R4");
    wr(3, 32'hAA0B0C0D, 4'b1000);
    rd(3, 32'hAA605040, "R4");

    // R5: out-of-range sources park the line; 127 still routes
    cur_tag = "R5";
    wr(3, 32'h807FFF80, 4'hF);
    evt_cur = '1;
    idle(); idle();
    evt_cur = '0; evt_cur[127] = 1'b1;
    idle(); idle();
    rd(3, 32'h807FFF80, "R5");

    // R6 / R7: reserved and unmapped words
    cur_tag = "R6";
    wr(0, 32'h01010101, 4'hF);
    rd(0, 32'h0, "R6");
    cur_tag = "R7";
    for (int a = 4; a < 8; a++) wr(a, 32'h02020202, 4'hF);
    for (int a = 4; a < 8; a++) rd(a, 32'h0, "R7");
    rd_model(1, "R6");
    rd_model(2, "R7");
    evt_cur = pattern(50); idle(); idle();

    // R10: all lines on one event
    cur_tag = "R10";
    wr(1, 32'h09090909, 4'hF);
    wr(2, 32'h09090909, 4'hF);
    wr(3, 32'h09090909, 4'hF);
    for (int k = 0; k < 6; k++) begin evt_cur = '0; evt_cur[9] = k[0]; idle(); end

    // R9: read data holds while no read is requested
    rd(2, 32'h09090909, "R9");
    wr(2, 32'h33333333, 4'hF);
    cycle(0, 0, 2, '0, '0, d);
    cycle(0, 0, 2, '0, '0, d);
    check(d == 32'h09090909, "R9", d, 32'h09090909);

    idle(); idle();
    done = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog actual=%h expected=%h", 32'h0, 32'h1);
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end
endmodule